// File: doc/BRIEF.md
# Magic packet wake detector

This block scans the received byte stream of a network interface while the node sleeps, looking for a wake-up pattern: a run of at least six `0xFF` bytes followed directly by sixteen back-to-back copies of the node's own 48-bit station address. The pattern may sit anywhere in the frame. Only frames whose destination field (the first six bytes) equals the station address are considered.

Each received byte arrives as a beat with `in_valid`, flagged as the first and/or last byte of its frame. Matching state is rebuilt from scratch at every frame start, so a pattern split across two frames is never recognised. When a frame that held the complete pattern ends, a sticky status flag is set. The wake output follows that flag while the host allows wake signalling. The host clears the flag explicitly.

Top module: `magic_wake_detector`

## Requirements
- R1: After reset, `wake_evt` and `wake` are both 0.
- R2: A frame whose bytes 0..5 equal `station_addr` (byte 0 is bits 47:40, byte 5 is bits 7:0) and that contains six `0xFF` bytes followed immediately by 16 copies of the address in the same byte order sets `wake_evt`. It is set in the cycle after the clock edge that takes the frame's last byte, and not earlier, even when the pattern completes before the last byte.
- R3: A frame whose first six bytes differ from the station address, or that has fewer than six bytes, never sets `wake_evt`.
- R4: Fewer than 16 copies, or any wrong byte inside the copies, breaks the match. The search then restarts, and the wrong byte counts as the first sync byte if it is `0xFF`. A complete pattern later in the same frame is still detected.
- R5: A sync run longer than six `0xFF` bytes is valid, and its last six bytes form the sync. A run of five or fewer is not valid.
- R6: A beat with `in_first` restarts the search and the address check, including in the middle of a frame. A pattern split across two frames is not detected.
- R7: Detection only takes place for frames that start and end while both `mode_en` and `asleep` are 1. If either drops during a frame, that frame is not detected.
- R8: `wake_evt` stays set until the host asserts `evt_clr` for one cycle. If a detection and `evt_clr` fall in the same cycle, the flag is set.
- R9: `wake` is 1 exactly when `wake_evt` and `evt_en` are both 1. `evt_en` has no effect on `wake_evt`.
- R10: Cycles with `in_valid` low are ignored. Bytes that arrive before any `in_first` (outside a frame) are ignored, including one flagged `in_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Magic-pattern wake mode enabled |
| asleep | input | 1 | Node is in a low-power state |
| evt_en | input | 1 | Allows the wake output to follow the status flag |
| evt_clr | input | 1 | Clears the status flag |
| station_addr | input | 48 | Node's own station address |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | Byte is the first of its frame |
| in_last | input | 1 | Byte is the last of its frame |
| wake_evt | output | 1 | Sticky wake-event status |
| wake | output | 1 | Wake request |

## Verification
The bench builds the block with its default values: a six-byte sync, sixteen copies and a six-byte address. With these values the full 102-byte pattern fits easily in frames of under 150 bytes, so random frames can hit it, miss it by one copy, carry a corrupted copy, or have sync runs of three to nine bytes. Station addresses are drawn without `0xFF` bytes, so the brute-force window search in the bench defines the expected result without ambiguity.

// File: rtl/magic_wake_detector.sv
module magic_wake_detector #(
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_en,
  input  logic                    asleep,
  input  logic                    evt_en,
  input  logic                    evt_clr,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic                    in_first,
  input  logic                    in_last,
  output logic                    wake_evt,
  output logic                    wake
);
  localparam int AW = 8*ADDR_BYTES;
  localparam int SW = $clog2(SYNC_LEN+1);
  localparam int RW = $clog2(REPS+1);
  localparam int PW = $clog2(ADDR_BYTES);
  localparam int HW = $clog2(ADDR_BYTES+1);
  localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
  localparam logic [PW-1:0] POS_LAST  = PW'(ADDR_BYTES-1);
  localparam logic [RW-1:0] REP_LAST  = RW'(REPS-1);
  localparam logic [HW-1:0] HDR_DONE  = HW'(ADDR_BYTES);

  logic          scan, active, start, take, hit, is_ff;
  logic [HW-1:0] hdr_cnt, b_hdr, n_hdr;
  logic          addr_ok, b_aok, n_aok;
  logic [SW-1:0] ff_cnt, b_ff, n_ff;
  logic          in_body, b_body, n_body;
  logic [PW-1:0] pos, b_pos, n_pos;
  logic [RW-1:0] rep, b_rep, n_rep;
  logic          found, b_found, n_found;

  function automatic logic [7:0] addr_byte(input int idx);
    return station_addr[AW-8-8*idx +: 8];
  endfunction

  assign active = mode_en & asleep;
  assign start  = in_valid & in_first;
  assign take   = in_valid & active & (start | scan);
  assign is_ff  = (in_data == 8'hFF);

  assign b_hdr   = start ? '0 : hdr_cnt;
  assign b_aok   = start | addr_ok;
  assign b_ff    = start ? '0 : ff_cnt;
  assign b_body  = ~start & in_body;
  assign b_pos   = start ? '0 : pos;
  assign b_rep   = start ? '0 : rep;
  assign b_found = ~start & found;

  always_comb begin
    n_hdr   = b_hdr;
    n_aok   = b_aok;
    n_ff    = b_ff;
    n_body  = b_body;
    n_pos   = b_pos;
    n_rep   = b_rep;
    n_found = b_found;
    if (b_hdr != HDR_DONE) begin
      n_hdr = b_hdr + 1'b1;
      n_aok = b_aok & (in_data == addr_byte(int'(b_hdr)));
    end
    if (!b_found) begin
      if (b_body) begin
        if (in_data == addr_byte(int'(b_pos))) begin
          if (b_pos == POS_LAST) begin
            n_pos = '0;
            if (b_rep == REP_LAST) begin
              n_found = 1'b1;
              n_body  = 1'b0;
              n_rep   = '0;
            end else begin
              n_rep = b_rep + 1'b1;
            end
          end else begin
            n_pos = b_pos + 1'b1;
          end
        end else begin
          n_body = 1'b0;
          n_pos  = '0;
          n_rep  = '0;
          n_ff   = is_ff ? SW'(1) : '0;
        end
      end else if (b_ff == SYNC_FULL && in_data == addr_byte(0)) begin
        n_body = 1'b1;
        n_pos  = PW'(1);
        n_rep  = '0;
        n_ff   = '0;
      end else if (is_ff) begin
        n_ff = (b_ff == SYNC_FULL) ? b_ff : b_ff + 1'b1;
      end else begin
        n_ff = '0;
      end
    end
  end

  assign hit  = take & in_last & n_found & n_aok & (n_hdr == HDR_DONE);
  assign wake = wake_evt & evt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan     <= 1'b0;
      hdr_cnt  <= '0;
      addr_ok  <= 1'b0;
      ff_cnt   <= '0;
      in_body  <= 1'b0;
      pos      <= '0;
      rep      <= '0;
      found    <= 1'b0;
      wake_evt <= 1'b0;
    end else begin
      if (!active)                 scan <= 1'b0;
      else if (start)              scan <= ~in_last;
      else if (in_valid & in_last) scan <= 1'b0;
      if (take) begin
        hdr_cnt <= n_hdr;
        addr_ok <= n_aok;
        ff_cnt  <= n_ff;
        in_body <= n_body;
        pos     <= n_pos;
        rep     <= n_rep;
        found   <= n_found;
      end
      if (hit)          wake_evt <= 1'b1;
      else if (evt_clr) wake_evt <= 1'b0;
    end
  end
endmodule

// File: rtl/magic_wake_checker.sv
module magic_wake_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic asleep,
  input logic evt_en,
  input logic evt_clr,
  input logic in_valid,
  input logic in_last,
  input logic wake_evt,
  input logic wake
);
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !evt_en |-> !wake); // R9
  AST_WAKE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n) !wake_evt |-> !wake); // R9
  AST_SET_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(wake_evt) |-> $past(in_valid && in_last)); // R2
  AST_SET_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) $rose(wake_evt) |-> $past(mode_en && asleep)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wake_evt && !evt_clr |=> wake_evt); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) wake_evt && evt_clr && !(in_valid && in_last) |=> !wake_evt); // R8
endmodule

bind magic_wake_detector magic_wake_checker u_magic_wake_checker (.*);

// File: tb/test_magic_wake_detector.sv
module test_magic_wake_detector;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0, asleep = 1'b0, evt_en = 1'b0, evt_clr = 1'b0;
  logic [47:0] station_addr = 48'h0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = 8'h0;
  logic        wake_evt, wake;

  int checks = 0, failures = 0;
  logic [7:0] fb [0:511];
  int flen = 0;
  bit early;

  always #(CLK_PERIOD/2) clk = ~clk;

  magic_wake_detector i_magic_wake_detector (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .asleep(asleep), .evt_en(evt_en),
    .evt_clr(evt_clr), .station_addr(station_addr), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .wake_evt(wake_evt), .wake(wake)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ab(input int i);
    return station_addr[47-8*i -: 8];
  endfunction

  task automatic put(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask
  task automatic put_dest(input bit good);
    for (int i = 0; i < 6; i++) put(good ? ab(i) : (i == 3 ? ab(i) ^ 8'h10 : ab(i)));
  endtask
  task automatic put_ff(input int n);
    for (int i = 0; i < n; i++) put(8'hFF);
  endtask
  task automatic put_body(input int reps);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < 6; i++) put(ab(i));
  endtask

  function automatic bit model_hit();
    bit ok;
    if (flen < 6) return 1'b0;
    for (int i = 0; i < 6; i++) if (fb[i] != ab(i)) return 1'b0;
    for (int p = 6; p + 96 <= flen; p++) begin
      ok = 1'b1;
      for (int k = 1; k <= 6; k++) if (fb[p-k] != 8'hFF) ok = 1'b0;
      for (int k = 0; k < 96; k++) if (fb[p+k] != ab(k % 6)) ok = 1'b0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'($urandom);
    in_first = 1'($urandom);
    in_last  = 1'($urandom);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    in_valid = 1'b0;
    evt_clr = 1'b1;
    @(negedge clk);
    evt_clr = 1'b0;
  endtask

  task automatic send(input bit gaps, input int drop_at, input int first_at,
                      input bit clr_last, input bit nofirst);
    logic start_val;
    start_val = wake_evt;
    early = 1'b0;
    for (int i = 0; i < flen; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle();
      @(negedge clk);
      if (i > 0 && wake_evt !== start_val) early = 1'b1;
      in_valid = 1'b1;
      in_data  = fb[i];
      in_first = !nofirst && (i == 0 || i == first_at);
      in_last  = (i == flen - 1);
      if (i == drop_at) asleep = 1'b0;
      evt_clr  = clr_last && (i == flen - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    evt_clr  = 1'b0;
    asleep   = 1'b1;
  endtask

  task automatic run(input string req, input bit exp, input bit gaps = 0, input int drop_at = -1,
                     input int first_at = -1, input bit clr_last = 0, input bit nofirst = 0);
    pulse_clr();
    send(gaps, drop_at, first_at, clr_last, nofirst);
    check({req, " no early set"}, early, 1'b0);
    check({req, " wake_evt"}, wake_evt, exp);
    check({req, " wake"}, wake, exp & evt_en);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cut, sl, rp;
    void'($urandom(32'd20240611));
    station_addr = 48'h02A1B2C3D4E5;
    repeat (3) @(negedge clk);
    check("R1 reset wake_evt", wake_evt, 1'b0);
    check("R1 reset wake", wake, 1'b0);
    rst_n = 1'b1;
    mode_en = 1'b1; asleep = 1'b1; evt_en = 1'b1;
    @(negedge clk);
    check("R1 after reset", wake_evt, 1'b0);

    flen = 0; put_dest(1); put_ff(6); put_body(16); put(8'h11); put(8'h22); put(8'h33);
    run("R2 basic", 1'b1);
    flen = 0; put_dest(1); put(8'h05); put_ff(6); put_body(16);
    run("R2 pattern ends frame", 1'b1);

    flen = 0; put_dest(0); put_ff(6); put_body(16); put(8'h00);
    run("R3 wrong destination", 1'b0);
    flen = 0; put(ab(0)); put(ab(1)); put(ab(2)); put(ab(3));
    run("R3 short frame", 1'b0);

    flen = 0; put_dest(1); put_ff(6); put_body(15); put(8'h00);
    run("R4 fifteen copies", 1'b0);
    flen = 0; put_dest(1); put_ff(6); put_body(3); put(ab(0)); put(ab(1)); put(8'hFF);
    put_ff(5); put_body(16);
    run("R4 mismatch 0xFF restarts sync", 1'b1);
    flen = 0; put_dest(1); put_ff(6); put_body(3); put(ab(0)); put(8'h00);
    put_ff(5); put_body(16);
    run("R4 mismatch non-FF, five FF", 1'b0);
    flen = 0; put_dest(1); put_ff(6); put_body(7); put(8'h44); put_ff(6); put_body(16); put(8'h01);
    run("R4 later full pattern", 1'b1);

    flen = 0; put_dest(1); put_ff(9); put_body(16);
    run("R5 long sync", 1'b1);
    flen = 0; put_dest(1); put(8'h00); put_ff(5); put_body(16);
    run("R5 short sync", 1'b0);

    flen = 0; put_dest(1); put_ff(6); put_body(10);
    run("R6 span part A", 1'b0);
    flen = 0; put_dest(1); put_body(6);
    pulse_clr(); send(0, -1, -1, 0, 0);
    check("R6 span part B", wake_evt, 1'b0);
    flen = 0; put_dest(1); put_ff(6); put_body(8); cut = flen; put_dest(1); put_body(8);
    run("R6 restart mid-frame loses pattern", 1'b0, 0, -1, cut);
    flen = 0; put_dest(0); put(8'h77); cut = flen; put_dest(1); put_ff(6); put_body(16);
    run("R6 restart mid-frame new frame addressed", 1'b1, 0, -1, cut);

    mode_en = 1'b0;
    flen = 0; put_dest(1); put_ff(6); put_body(16);
    run("R7 mode disabled", 1'b0);
    mode_en = 1'b1; asleep = 1'b0;
    pulse_clr(); send(0, -1, -1, 0, 0);
    check("R7 awake", wake_evt, 1'b0);
    asleep = 1'b1;
    run("R7 sleep left mid-frame", 1'b0, 0, 20);
    run("R7 back asleep", 1'b1);

    repeat (20) idle();
    check("R8 sticky over idle", wake_evt, 1'b1);
    flen = 0; put_dest(0); put(8'h00);
    send(0, -1, -1, 0, 0);
    check("R8 sticky over other frame", wake_evt, 1'b1);
    pulse_clr();
    check("R8 cleared", wake_evt, 1'b0);
    flen = 0; put_dest(1); put_ff(6); put_body(16);
    run("R8 set beats clear", 1'b1, 0, -1, -1, 1);

    evt_en = 1'b0;
    run("R9 disabled output", 1'b1);
    check("R9 wake low", wake, 1'b0);
    evt_en = 1'b1;
    #1;
    check("R9 wake follows enable", wake, 1'b1);

    run("R10 gaps in stream", 1'b1, 1);
    run("R10 bytes outside frame", 1'b0, 0, -1, -1, 0, 1);

    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < 6; i++)
        station_addr[47-8*i -: 8] = 8'($urandom % 255);
      station_addr[40] = 1'b0;
      evt_en = 1'($urandom % 4 != 0);
      flen = 0;
      put_dest($urandom % 8 != 0);
      for (int i = $urandom % 20; i > 0; i--) put(($urandom % 5 == 0) ? 8'hFF : 8'($urandom));
      if ($urandom % 6 != 0) begin
        sl = 3 + $urandom % 7;
        rp = 13 + $urandom % 5;
        put_ff(sl);
        cut = flen;
        put_body(rp);
        if ($urandom % 4 == 0) fb[cut + $urandom % (rp*6)] = 8'($urandom);
      end
      for (int i = $urandom % 10; i > 0; i--) put(8'($urandom));
      run("R2 R4 R5 random frame", model_hit(), 1'($urandom % 3 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule